// File: doc/BRIEF.md
# Graphics Plane Descriptor Fetcher

This block drives the parameters of one graphics plane into a display mixer. The plane's state is not written directly by software. Software builds small descriptors ("nodes") in memory and points the block at one of them. On each vertical sync the block reads the pointed-to node, sixteen 32-bit words long, one word per memory request. It then switches all plane parameters to the new node in a single step. The node's own link word becomes the pointer for the following sync.

Two nodes that link to each other make the hardware alternate between them on every sync, which suits interlaced top and bottom fields. Software double-buffers by editing the nodes not currently in use and then redirecting the pointer. Malformed pointers and syncs that arrive while a fetch is still running raise sticky error flags and leave the plane unchanged.

Top module: `plane_node_fetcher`

## Requirements
- R1: After reset the plane is invalid (plane_valid low), every parameter output and both error flags are zero, the pointer register reads 0, and no memory request is issued until a sync arrives.
- R2: A write to register offset 0x24 stores the node pointer, which reads back at offset 0x24. The write alone issues no memory request and leaves every plane output unchanged.
- R3: At a sync with a non-zero, 16-byte-aligned pointer, the block issues exactly sixteen single-cycle read requests, at pointer + 4*i for i = 0..15 in increasing order. Only one request is outstanding at any time.
- R4: Node fields, by byte offset within the node:
  - 0x00 is control: format = bits 4:0, alpha_full = bit 5, wait_sync = bit 31.
  - 0x0C is origin and 0x10 is stop: each packs a line in bits 31:16 and a pixel in bits 15:0.
  - 0x14 is the base address and 0x18 is the pitch.
  - 0x1C is size: height = bits 26:16, width = bits 10:0; other bits are ignored.
- R5: All plane outputs change together, in the cycle after the sixteenth word of a node returns, and not earlier.
- R6: When a node is applied, the pointer register takes the node's word at byte offset 0x24. Two nodes linked to each other are applied alternately on successive syncs.
- R7: A register read at offset 0x14 returns the applied base address. Offsets other than 0x14 and 0x24 read zero.
- R8: Once a node has been applied, plane_valid is low when bits 1:0 of the node word at offset 0x34 are both 1, and high for the other three values.
- R9: A sync with a zero pointer issues no request and changes no output or flag.
- R10: A sync with a pointer whose low four bits are not all zero issues no request, keeps every plane output, and sets err_align, which stays set until reset.
- R11: A sync during a fetch sets err_overrun (sticky until reset). The node being fetched is read to the end but discarded: outputs and pointer stay unchanged.
- R12: field_bottom takes the value of field_in sampled at each sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr_en | input | 1 | register write strobe |
| reg_addr | input | 8 | register byte offset (write and read) |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for reg_addr |
| vsync | input | 1 | one-cycle vertical sync pulse |
| field_in | input | 1 | 1 when the coming field is the bottom field |
| mem_req | output | 1 | one-cycle word read request |
| mem_addr | output | 32 | byte address of the requested word |
| mem_rvalid | input | 1 | read data returned |
| mem_rdata | input | 32 | returned word |
| plane_valid | output | 1 | plane is to be shown by the mixer |
| plane_format | output | 5 | colour format code |
| plane_alpha_full | output | 1 | alpha range 0..255 selected |
| plane_wait_sync | output | 1 | wait-for-sync control bit |
| plane_base | output | 32 | pixel memory base address |
| plane_pitch | output | 32 | line pitch in bytes |
| plane_width | output | 11 | source width |
| plane_height | output | 11 | source height |
| plane_org_line | output | 16 | viewport origin line |
| plane_org_pix | output | 16 | viewport origin pixel |
| plane_stop_line | output | 16 | viewport stop line |
| plane_stop_pix | output | 16 | viewport stop pixel |
| field_bottom | output | 1 | field captured at the last sync |
| err_align | output | 1 | sticky misaligned-pointer flag |
| err_overrun | output | 1 | sticky sync-during-fetch flag |

## Verification
On every cycle, the embedded properties check four things:
- read requests are single-cycle pulses on word-aligned addresses;
- a zero pointer never starts a fetch;
- plane outputs move only in the cycle after a completed, undiscarded node;
- the pointer moves only after a register write or a node commit.

The bench's scenarios are needed for the rest: the exact field decoding, the sixteen-address order, the commit cycle, top/bottom alternation, the ignore encoding, and the fate of nodes hit by a misaligned pointer or an overrun. It sweeps all 32 format codes and all four ignore-bit patterns against values computed from per-node seeds.

// File: rtl/pnf_pkg.sv
package pnf_pkg;

    localparam int unsigned NODE_WORDS = 16;
    localparam int unsigned IDX_W      = $clog2(NODE_WORDS);
    localparam int unsigned ALIGN_BITS = 4;

    // word indices inside a node (byte offset / 4)
    localparam logic [IDX_W-1:0] W_CTL   = IDX_W'(0);
    localparam logic [IDX_W-1:0] W_ORG   = IDX_W'(3);
    localparam logic [IDX_W-1:0] W_STOP  = IDX_W'(4);
    localparam logic [IDX_W-1:0] W_BASE  = IDX_W'(5);
    localparam logic [IDX_W-1:0] W_PITCH = IDX_W'(6);
    localparam logic [IDX_W-1:0] W_SIZE  = IDX_W'(7);
    localparam logic [IDX_W-1:0] W_LINK  = IDX_W'(9);
    localparam logic [IDX_W-1:0] W_PROPS = IDX_W'(13);

    // register byte offsets
    localparam logic [7:0] REG_LINK = 8'h24;
    localparam logic [7:0] REG_BASE = 8'h14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_st_e;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] org;
        logic [31:0] stp;
        logic [31:0] base;
        logic [31:0] pitch;
        logic [31:0] size;
        logic [31:0] props;
    } plane_t;

endpackage

// File: rtl/pnf_ptr_reg.sv
module pnf_ptr_reg #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (load_en) d.ptr = load_val;
        if (wr_en)   d.ptr = wr_val;   // software write wins
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr = q.ptr;

    a_r6_ptr_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.ptr) |-> $past(wr_en || load_en));

endmodule

// File: rtl/pnf_walker.sv
module pnf_walker
    import pnf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic [ADDR_W-1:0] ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              word_vld,
    output logic [IDX_W-1:0]  word_idx,
    output logic [31:0]       word_data,
    output logic              node_done,
    output logic              busy,
    output logic              err_align,
    output logic              err_overrun
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic              discard;
        logic              err_a;
        logic              err_o;
    } st_t;

    st_t d, q;
    logic done_c;

    always_comb begin
        d      = q;
        done_c = 1'b0;
        if (vsync && q.st != ST_IDLE) begin
            d.discard = 1'b1;
            d.err_o   = 1'b1;
        end
        case (q.st)
            ST_IDLE: begin
                if (vsync && ptr != '0) begin
                    if (ptr[ALIGN_BITS-1:0] != '0) begin
                        d.err_a = 1'b1;
                    end else begin
                        d.st      = ST_REQ;
                        d.base    = ptr;
                        d.idx     = '0;
                        d.discard = 1'b0;
                    end
                end
            end
            ST_REQ: d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    if (q.idx == LAST_IDX) begin
                        d.st   = ST_IDLE;
                        done_c = !d.discard;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_REQ;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req     = (q.st == ST_REQ);
    assign mem_addr    = q.base + (ADDR_W'(q.idx) << 2);
    assign word_vld    = (q.st == ST_WAIT) && mem_rvalid;
    assign word_idx    = q.idx;
    assign word_data   = mem_rdata;
    assign node_done   = done_c;
    assign busy        = (q.st != ST_IDLE);
    assign err_align   = q.err_a;
    assign err_overrun = q.err_o;

    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r3_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r9_zero_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !busy && ptr == '0) |=> !busy);

    a_r10_align_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_align) |-> err_align);

    a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_overrun) |-> err_overrun);

endmodule

// File: rtl/pnf_shadow.sv
module pnf_shadow
    import pnf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [31:0]       word_data,
    input  logic              node_done,
    output plane_t            act,
    output logic              loaded,
    output logic [ADDR_W-1:0] link
);

    typedef struct packed {
        plane_t            shd;
        logic [ADDR_W-1:0] shd_link;
        plane_t            act;
        logic              loaded;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (word_vld) begin
            case (word_idx)
                W_CTL:   d.shd.ctl   = word_data;
                W_ORG:   d.shd.org   = word_data;
                W_STOP:  d.shd.stp   = word_data;
                W_BASE:  d.shd.base  = word_data;
                W_PITCH: d.shd.pitch = word_data;
                W_SIZE:  d.shd.size  = word_data;
                W_LINK:  d.shd_link  = word_data[ADDR_W-1:0];
                W_PROPS: d.shd.props = word_data;
                default: ;
            endcase
        end
        if (node_done) begin
            d.act    = q.shd;
            d.loaded = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act    = q.act;
    assign loaded = q.loaded;
    assign link   = q.shd_link;

    a_r5_atomic_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.act) |-> $past(node_done));

    a_r5_loaded_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.loaded) |-> $past(node_done));

endmodule

// File: rtl/plane_node_fetcher.sv
module plane_node_fetcher
    import pnf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        vsync,
    input  logic        field_in,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        plane_valid,
    output logic [4:0]  plane_format,
    output logic        plane_alpha_full,
    output logic        plane_wait_sync,
    output logic [31:0] plane_base,
    output logic [31:0] plane_pitch,
    output logic [10:0] plane_width,
    output logic [10:0] plane_height,
    output logic [15:0] plane_org_line,
    output logic [15:0] plane_org_pix,
    output logic [15:0] plane_stop_line,
    output logic [15:0] plane_stop_pix,
    output logic        field_bottom,
    output logic        err_align,
    output logic        err_overrun
);

    localparam int unsigned ADDR_W = 32;

    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] link;
    logic              ptr_wr;
    logic              word_vld;
    logic [IDX_W-1:0]  word_idx;
    logic [31:0]       word_data;
    logic              node_done;
    logic              busy;
    logic              loaded;
    plane_t            act;

    typedef struct packed {
        logic field;
    } top_st_t;

    top_st_t d, q;

    assign ptr_wr = reg_wr_en && (reg_addr == REG_LINK);

    pnf_ptr_reg #(.ADDR_W(ADDR_W)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ptr_wr),
        .wr_val   (reg_wdata),
        .load_en  (node_done),
        .load_val (link),
        .ptr      (ptr)
    );

    pnf_walker #(.ADDR_W(ADDR_W)) walk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync       (vsync),
        .ptr         (ptr),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .word_vld    (word_vld),
        .word_idx    (word_idx),
        .word_data   (word_data),
        .node_done   (node_done),
        .busy        (busy),
        .err_align   (err_align),
        .err_overrun (err_overrun)
    );

    pnf_shadow #(.ADDR_W(ADDR_W)) shd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (word_vld),
        .word_idx  (word_idx),
        .word_data (word_data),
        .node_done (node_done),
        .act       (act),
        .loaded    (loaded),
        .link      (link)
    );

    always_comb begin
        d = q;
        if (vsync) d.field = field_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            REG_LINK: reg_rdata = ptr;
            REG_BASE: reg_rdata = act.base;
            default:  reg_rdata = '0;
        endcase
    end

    assign plane_valid      = loaded && (act.props[1:0] != 2'b11);
    assign plane_format     = act.ctl[4:0];
    assign plane_alpha_full = act.ctl[5];
    assign plane_wait_sync  = act.ctl[31];
    assign plane_base       = act.base;
    assign plane_pitch      = act.pitch;
    assign plane_width      = act.size[10:0];
    assign plane_height     = act.size[26:16];
    assign plane_org_line   = act.org[31:16];
    assign plane_org_pix    = act.org[15:0];
    assign plane_stop_line  = act.stp[31:16];
    assign plane_stop_pix   = act.stp[15:0];
    assign field_bottom     = q.field;

    logic unused_bits;
    assign unused_bits = ^{act.ctl[30:6], act.size[31:27], act.size[15:11],
                           act.props[31:2], busy};

endmodule

// File: tb/plane_node_fetcher_tb_top.sv
module plane_node_fetcher_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        vsync = 1'b0;
    logic        field_in = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        plane_valid, plane_alpha_full, plane_wait_sync;
    logic [4:0]  plane_format;
    logic [31:0] plane_base, plane_pitch;
    logic [10:0] plane_width, plane_height;
    logic [15:0] plane_org_line, plane_org_pix, plane_stop_line, plane_stop_pix;
    logic        field_bottom, err_align, err_overrun;

    int n_chk = 0;
    int n_fail = 0;
    int req_cnt = 0;
    logic [31:0] mem [0:63];
    logic [31:0] addr_log [0:255];

    always #5 clk = ~clk;

    plane_node_fetcher dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vsync(vsync),
        .field_in(field_in), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .plane_valid(plane_valid), .plane_format(plane_format),
        .plane_alpha_full(plane_alpha_full), .plane_wait_sync(plane_wait_sync),
        .plane_base(plane_base), .plane_pitch(plane_pitch),
        .plane_width(plane_width), .plane_height(plane_height),
        .plane_org_line(plane_org_line), .plane_org_pix(plane_org_pix),
        .plane_stop_line(plane_stop_line), .plane_stop_pix(plane_stop_pix),
        .field_bottom(field_bottom), .err_align(err_align),
        .err_overrun(err_overrun)
    );

    // memory model: one-cycle latency, one word per request
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        if (mem_req) begin
            mem_rdata <= mem[mem_addr[7:2]];
            addr_log[req_cnt[7:0]] <= mem_addr;
            req_cnt <= req_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] e_org(input int s);
        return {16'(s * 3 + 1), 16'(s * 5 + 2)};
    endfunction
    function automatic logic [31:0] e_stp(input int s);
        return {16'(s * 3 + 100), 16'(s * 5 + 200)};
    endfunction
    function automatic logic [31:0] e_base(input int s);
        return 32'h1000_0000 + 32'(s) * 32'h100;
    endfunction
    function automatic logic [31:0] e_pitch(input int s);
        return 32'(s * 64 + 4);
    endfunction
    function automatic logic [10:0] e_w(input int s);
        return 11'(s * 91 + 5);
    endfunction
    function automatic logic [10:0] e_h(input int s);
        return 11'(s * 37 + 3);
    endfunction
    function automatic logic [31:0] mk_ctl(input int f);
        return 32'(f & 31) | (32'((f >> 1) & 1) << 5) | (32'(f & 1) << 31);
    endfunction

    task automatic build_node(input logic [31:0] a, input int s, input logic [31:0] ctl,
                              input logic [31:0] lnk, input logic [31:0] props);
        for (int i = 0; i < 16; i++) mem[a[7:2] + 6'(i)] = 32'hA500_0000 + 32'(i);
        mem[a[7:2] + 6'd0]  = ctl;
        mem[a[7:2] + 6'd3]  = e_org(s);
        mem[a[7:2] + 6'd4]  = e_stp(s);
        mem[a[7:2] + 6'd5]  = e_base(s);
        mem[a[7:2] + 6'd6]  = e_pitch(s);
        mem[a[7:2] + 6'd7]  = 32'hF800_F800 | (32'(e_h(s)) << 16) | 32'(e_w(s));
        mem[a[7:2] + 6'd9]  = lnk;
        mem[a[7:2] + 6'd13] = props;
    endtask

    task automatic write_ptr(input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'h24; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(input logic f);
        @(negedge clk);
        vsync = 1'b1; field_in = f;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic fetch(input logic f);
        pulse(f);
        repeat (36) @(negedge clk);
    endtask

    task automatic chk_geom(input string tag, input int s);
        chk({tag, " origin"}, {plane_org_line, plane_org_pix}, e_org(s));
        chk({tag, " stop"}, {plane_stop_line, plane_stop_pix}, e_stp(s));
        chk({tag, " base"}, plane_base, e_base(s));
        chk({tag, " pitch"}, plane_pitch, e_pitch(s));
        chk({tag, " size"}, {5'd0, plane_height, 5'd0, plane_width}, {5'd0, e_h(s), 5'd0, e_w(s)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int c0;
        int s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(plane_valid), 0);
        chk("R1 errors", {30'd0, err_align, err_overrun}, 0);
        chk("R1 base", plane_base, 0);
        rd(8'h24, v); chk("R1 ptr", v, 0);
        chk("R1 no request", 32'(req_cnt), 0);

        build_node(32'h40, 1, mk_ctl(1), 32'h80, 32'h0);
        build_node(32'h80, 2, mk_ctl(2), 32'h40, 32'h0);

        // R2 write does not apply before sync
        write_ptr(32'h40);
        repeat (5) @(negedge clk);
        rd(8'h24, v); chk("R2 ptr readback", v, 32'h40);
        chk("R2 valid unchanged", 32'(plane_valid), 0);
        chk("R2 base unchanged", plane_base, 0);
        chk("R2 no request", 32'(req_cnt), 0);

        // R5 commit exactly after 16th word
        c0 = req_cnt;
        pulse(1'b0);
        repeat (31) @(negedge clk);
        chk("R5 before last word", plane_base, 0);
        @(negedge clk);
        chk("R5 after last word", plane_base, e_base(1));
        chk("R8 valid", 32'(plane_valid), 1);
        chk_geom("R4 node1", 1);
        chk("R4 ctl", {plane_wait_sync, plane_alpha_full, plane_format}, {1'b1, 1'b0, 5'd1});
        rd(8'h24, v); chk("R6 link loaded", v, 32'h80);
        rd(8'h14, v); chk("R7 base read", v, e_base(1));
        rd(8'h00, v); chk("R7 other offset", v, 0);
        chk("R3 count", 32'(req_cnt - c0), 16);
        for (int i = 0; i < 16; i++)
            chk("R3 address", addr_log[8'(c0 + i)], 32'h40 + 32'(4 * i));

        // R6 alternation
        for (int k = 0; k < 6; k++) begin
            fetch(1'b0);
            s = (k % 2 == 0) ? 2 : 1;
            chk_geom("R6 alternate", s);
            rd(8'h24, v); chk("R6 next ptr", v, (s == 2) ? 32'h40 : 32'h80);
        end

        // R4 format sweep, self-linked node
        build_node(32'h40, 1, mk_ctl(0), 32'h40, 32'h0);
        write_ptr(32'h40);
        for (int f = 0; f < 32; f++) begin
            mem[16] = mk_ctl(f);
            fetch(1'b0);
            chk("R4 format", {27'd0, plane_wait_sync, plane_alpha_full, plane_format},
                {27'd0, 1'(f & 1), 1'((f >> 1) & 1), 5'(f)});
        end

        // R8 ignore flags sweep
        for (int p = 0; p < 4; p++) begin
            mem[16 + 13] = 32'hFFFF_FFF0 | 32'(p);
            fetch(1'b0);
            chk("R8 ignore", 32'(plane_valid), (p == 3) ? 0 : 1);
        end
        mem[16 + 13] = 32'h0;
        fetch(1'b0);

        // R12 field capture
        fetch(1'b1);
        chk("R12 bottom", 32'(field_bottom), 1);
        fetch(1'b0);
        chk("R12 top", 32'(field_bottom), 0);

        // R9 zero pointer
        write_ptr(32'h0);
        c0 = req_cnt;
        fetch(1'b0);
        chk("R9 no request", 32'(req_cnt - c0), 0);
        chk_geom("R9 unchanged", 1);
        chk("R9 flags", {30'd0, err_align, err_overrun}, 0);

        // R10 misaligned pointer
        write_ptr(32'h44);
        c0 = req_cnt;
        fetch(1'b0);
        chk("R10 flag", 32'(err_align), 1);
        chk("R10 no request", 32'(req_cnt - c0), 0);
        chk_geom("R10 unchanged", 1);
        fetch(1'b0);
        chk("R10 sticky", 32'(err_align), 1);

        // R11 overrun
        build_node(32'hC0, 7, mk_ctl(3), 32'hC0, 32'h0);
        write_ptr(32'hC0);
        pulse(1'b0);
        repeat (10) @(negedge clk);
        pulse(1'b0);
        repeat (40) @(negedge clk);
        chk("R11 flag", 32'(err_overrun), 1);
        chk_geom("R11 discarded", 1);
        rd(8'h24, v); chk("R11 ptr kept", v, 32'hC0);
        fetch(1'b0);
        chk_geom("R11 retry", 7);
        chk("R11 sticky", 32'(err_overrun), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule